// File: doc/BRIEF.md
# Split-Byte Write Bridge for a 16-bit Compare Value

This block sits between an 8-bit processor bus and a 16-bit compare value that a comparator watches on every clock. Software reaches the 16-bit value through two byte addresses. A write to the upper-byte address only parks the byte in a shared staging latch. A later write to the lower-byte address joins the parked byte with the new lower byte and issues one 16-bit commit. Because both halves arrive together, the comparator never sees a half-updated value.

The commit goes to one of two destinations, chosen when the lower byte is written. When double buffering is on, it goes to the shadow buffer, which the timer copies into the live compare value at a moment of its own choosing. When double buffering is off, it goes straight to the live compare value. Reads do not use the staging latch: each byte address returns its half of the 16-bit value that the surrounding logic presents. Bus arbitration and the comparator itself sit outside the block.

Top module: `wide_reg_bridge`

## Requirements
- R1: A write to the upper-byte address (address 1) loads the staging latch and raises neither commit strobe in the next cycle.
- R2: A write to the lower-byte address (address 0) drives `commit_data_o` = {staging latch, written byte} in the cycle after the write, with the staging value on bits 15:8.
- R3: The lower-byte write raises `commit_buf_o` when `dbuf_en_i` is 1 in that write cycle, and raises `commit_reg_o` when it is 0. It never raises both.
- R4: While `bus_rd_i` is 1, `bus_rdata_o` returns `cmp_val_i[15:8]` at address 1 and `cmp_val_i[7:0]` at address 0, in the same cycle. Otherwise it returns 0x00.
- R5: A lower-byte write that has no upper-byte write before it commits the latch's current contents as the upper byte.
- R6: After reset the staging latch holds 0x00 and both strobes are low. Each commit strobe is high for exactly one clock per lower-byte write.
- R7: Reads at either byte address leave the staging latch unchanged.
- R8: Writes to any address other than 0 or 1 change neither the latch nor the strobes.
- R9: An upper-byte write in the cycle that shows a commit does not alter that commit's data. The new byte is used by the following lower-byte write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbuf_en_i | input | 1 | 1 = commit to the shadow buffer, 0 = commit to the live compare value |
| bus_addr_i | input | ADDR_W | Byte address on the processor bus |
| bus_wr_i | input | 1 | Write enable, one access per cycle |
| bus_rd_i | input | 1 | Read enable |
| bus_wdata_i | input | 8 | Write data byte |
| bus_rdata_o | output | 8 | Read data byte |
| cmp_val_i | input | 16 | Current 16-bit compare value offered for reads |
| commit_buf_o | output | 1 | One-cycle write strobe toward the shadow buffer |
| commit_reg_o | output | 1 | One-cycle write strobe toward the live compare value |
| commit_data_o | output | 16 | Joined 16-bit value that goes with either strobe |

## Verification
A commit is presented one cycle after its lower-byte write, so it can coincide with the next upper-byte write landing in the staging latch. This is the one overlap where a new byte could leak into a commit already in flight. The bench provokes it by issuing an upper-byte write in the cycle right after a lower-byte write. It checks that the visible commit still carries the old upper byte, and that the next lower-byte write carries the new one. Reads that fall between a staging write and its commit are also judged, by the commit data that follows.

// File: rtl/bb_pkg.sv
package bb_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  typedef struct packed {
    logic hi_wr;
    logic lo_wr;
    logic hi_rd;
    logic lo_rd;
  } acc_t;

  function automatic logic [WORD_W-1:0] join_bytes(input logic [BYTE_W-1:0] hi,
                                                   input logic [BYTE_W-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [BYTE_W-1:0] pick_byte(input logic [WORD_W-1:0] word,
                                                  input logic upper);
    return upper ? word[WORD_W-1:BYTE_W] : word[BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/bb_decode.sv
module bb_decode
  import bb_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int HI_ADDR = 1,
  parameter int LO_ADDR = 0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output acc_t              acc_o
);
  localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(HI_ADDR);
  localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(LO_ADDR);

  logic is_hi, is_lo;
  assign is_hi = (addr_i == HI_A);
  assign is_lo = (addr_i == LO_A);

  always_comb begin
    acc_o.hi_wr = wr_i & is_hi;
    acc_o.lo_wr = wr_i & is_lo;
    acc_o.hi_rd = rd_i & is_hi;
    acc_o.lo_rd = rd_i & is_lo;
  end
endmodule

// File: rtl/bb_stage.sv
module bb_stage
  import bb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] din_i,
  output logic [BYTE_W-1:0] hold_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold_o <= '0;
    else if (load_i) hold_o <= din_i;
  end
endmodule

// File: rtl/bb_commit.sv
module bb_commit
  import bb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_i,
  input  logic              to_buf_i,
  input  logic [BYTE_W-1:0] hi_i,
  input  logic [BYTE_W-1:0] lo_i,
  output logic              buf_we_o,
  output logic              reg_we_o,
  output logic [WORD_W-1:0] data_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_we_o <= 1'b0;
      reg_we_o <= 1'b0;
      data_o   <= '0;
    end else begin
      buf_we_o <= fire_i & to_buf_i;
      reg_we_o <= fire_i & ~to_buf_i;
      if (fire_i) data_o <= join_bytes(hi_i, lo_i);
    end
  end
endmodule

// File: rtl/wide_reg_bridge.sv
module wide_reg_bridge
  import bb_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int HI_ADDR = 1,
  parameter int LO_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbuf_en_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  input  logic [15:0]       cmp_val_i,
  output logic              commit_buf_o,
  output logic              commit_reg_o,
  output logic [15:0]       commit_data_o
);
  acc_t              acc;
  logic              stage_load;
  logic              commit_fire;
  logic [BYTE_W-1:0] stage_byte;

  bb_decode #(.ADDR_W(ADDR_W), .HI_ADDR(HI_ADDR), .LO_ADDR(LO_ADDR)) u_dec (
    .addr_i(bus_addr_i), .wr_i(bus_wr_i), .rd_i(bus_rd_i), .acc_o(acc)
  );

  assign stage_load  = acc.hi_wr;
  assign commit_fire = acc.lo_wr;

  bb_stage u_stage (
    .clk(clk), .rst_n(rst_n), .load_i(stage_load),
    .din_i(bus_wdata_i), .hold_o(stage_byte)
  );

  bb_commit u_commit (
    .clk(clk), .rst_n(rst_n), .fire_i(commit_fire), .to_buf_i(dbuf_en_i),
    .hi_i(stage_byte), .lo_i(bus_wdata_i),
    .buf_we_o(commit_buf_o), .reg_we_o(commit_reg_o), .data_o(commit_data_o)
  );

  always_comb begin
    if (acc.hi_rd || acc.lo_rd) bus_rdata_o = pick_byte(cmp_val_i, acc.hi_rd);
    else                        bus_rdata_o = '0;
  end
endmodule

// File: rtl/wide_reg_bridge_chk.sv
module wide_reg_bridge_chk #(
  parameter int ADDR_W  = 4,
  parameter int HI_ADDR = 1,
  parameter int LO_ADDR = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dbuf_en_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_wr_i,
  input logic              bus_rd_i,
  input logic [7:0]        bus_wdata_i,
  input logic [7:0]        bus_rdata_o,
  input logic [15:0]       cmp_val_i,
  input logic              commit_buf_o,
  input logic              commit_reg_o,
  input logic [15:0]       commit_data_o,
  input logic [7:0]        stage_byte
);
  logic hi_w, lo_w;
  assign hi_w = bus_wr_i && (bus_addr_i == ADDR_W'(HI_ADDR));
  assign lo_w = bus_wr_i && (bus_addr_i == ADDR_W'(LO_ADDR));

  p_hi_no_commit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hi_w |=> (!commit_buf_o && !commit_reg_o));

  p_join_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lo_w |=> (commit_data_o == {$past(stage_byte), $past(bus_wdata_i)}));

  p_to_buf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_w && dbuf_en_i) |=> (commit_buf_o && !commit_reg_o));

  p_to_reg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_w && !dbuf_en_i) |=> (commit_reg_o && !commit_buf_o));

  p_rd_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_i && bus_addr_i == ADDR_W'(HI_ADDR)) |-> (bus_rdata_o == cmp_val_i[15:8]));

  p_rd_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_i && bus_addr_i == ADDR_W'(LO_ADDR)) |-> (bus_rdata_o == cmp_val_i[7:0]));

  p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_w |=> (!commit_buf_o && !commit_reg_o));

  p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({commit_buf_o, commit_reg_o}));

  p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_w |=> $stable(stage_byte));
endmodule

bind wide_reg_bridge wide_reg_bridge_chk #(
  .ADDR_W(ADDR_W), .HI_ADDR(HI_ADDR), .LO_ADDR(LO_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dbuf_en_i(dbuf_en_i), .bus_addr_i(bus_addr_i),
  .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i), .bus_wdata_i(bus_wdata_i),
  .bus_rdata_o(bus_rdata_o), .cmp_val_i(cmp_val_i), .commit_buf_o(commit_buf_o),
  .commit_reg_o(commit_reg_o), .commit_data_o(commit_data_o), .stage_byte(stage_byte)
);

// File: tb/sim_wide_reg_bridge.sv
module sim_wide_reg_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_HI = 4'd1;
  localparam logic [ADDR_W-1:0] A_LO = 4'd0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dbuf_en_i = 1'b0;
  logic [ADDR_W-1:0] bus_addr_i = '0;
  logic bus_wr_i = 1'b0;
  logic bus_rd_i = 1'b0;
  logic [7:0] bus_wdata_i = '0;
  logic [7:0] bus_rdata_o;
  logic [15:0] cmp_val_i = '0;
  logic commit_buf_o, commit_reg_o;
  logic [15:0] commit_data_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wide_reg_bridge #(.ADDR_W(ADDR_W)) u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive a one-cycle write at a falling edge; returns at the next falling edge,
  // where any commit it caused is already visible.
  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1;
    @(negedge clk);
    bus_wr_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R6 buf strobe at reset", 32'(commit_buf_o), 0);
    check("R6 reg strobe at reset", 32'(commit_reg_o), 0);
    @(negedge clk);
    dbuf_en_i = 1'b0;
    bus_write(A_LO, 8'h5A);
    check("R5/R6 latch reset 0x00", 32'(commit_data_o), 32'h005A);
    check("R3 reg strobe", 32'(commit_reg_o), 1);
    @(negedge clk);
    check("R6 strobe one cycle", 32'({commit_buf_o, commit_reg_o}), 0);
  endtask

  task automatic t_hi_then_lo();
    dbuf_en_i = 1'b1;
    bus_write(A_HI, 8'hC3);
    check("R1 no commit on high write", 32'({commit_buf_o, commit_reg_o}), 0);
    bus_write(A_LO, 8'h7E);
    check("R2 joined data", 32'(commit_data_o), 32'hC37E);
    check("R3 buf strobe", 32'({commit_buf_o, commit_reg_o}), 32'b10);
    @(negedge clk);
    check("R6 buf strobe one cycle", 32'(commit_buf_o), 0);
  endtask

  task automatic t_reuse_latch();
    dbuf_en_i = 1'b0;
    bus_write(A_LO, 8'h01);
    check("R5 stale high byte reused", 32'(commit_data_o), 32'hC301);
    check("R3 reg strobe", 32'({commit_buf_o, commit_reg_o}), 32'b01);
    @(negedge clk);
  endtask

  task automatic t_reads();
    cmp_val_i = 16'hBEEF;
    bus_write(A_HI, 8'hA5);
    bus_rd_i = 1'b1; bus_addr_i = A_HI; #1;
    check("R4 read high", 32'(bus_rdata_o), 32'hBE);
    @(negedge clk);
    bus_addr_i = A_LO; #1;
    check("R4 read low", 32'(bus_rdata_o), 32'hEF);
    @(negedge clk);
    check("R7 read gives no commit", 32'({commit_buf_o, commit_reg_o}), 0);
    bus_addr_i = 4'd5; #1;
    check("R4 other address reads 0", 32'(bus_rdata_o), 0);
    bus_rd_i = 1'b0; bus_addr_i = A_HI; #1;
    check("R4 no read gives 0", 32'(bus_rdata_o), 0);
    @(negedge clk);
    bus_write(A_LO, 8'h3C);
    check("R7 latch kept across reads", 32'(commit_data_o), 32'hA53C);
    @(negedge clk);
  endtask

  task automatic t_other_addr();
    bus_write(4'd7, 8'hFF);
    check("R8 no commit from foreign write", 32'({commit_buf_o, commit_reg_o}), 0);
    bus_write(4'd2, 8'h99);
    bus_write(A_LO, 8'h10);
    check("R8 latch unchanged", 32'(commit_data_o), 32'hA510);
    @(negedge clk);
  endtask

  task automatic t_back_to_back();
    dbuf_en_i = 1'b1;
    bus_write(A_HI, 8'h11);
    bus_write(A_LO, 8'h22);
    // Commit for 0x1122 is visible now; land a new high byte in this cycle.
    bus_addr_i = A_HI; bus_wdata_i = 8'h33; bus_wr_i = 1'b1; dbuf_en_i = 1'b0;
    #1;
    check("R9 commit data during new high write", 32'(commit_data_o), 32'h1122);
    check("R9 buf strobe during new high write", 32'(commit_buf_o), 1);
    @(negedge clk);
    bus_wr_i = 1'b0;
    check("R1/R9 no commit after high write", 32'({commit_buf_o, commit_reg_o}), 0);
    bus_write(A_LO, 8'h44);
    check("R9 next commit uses new high", 32'(commit_data_o), 32'h3344);
    check("R3 target follows enable at low write", 32'({commit_buf_o, commit_reg_o}), 32'b01);
    bus_write(A_LO, 8'h55);
    check("R6 consecutive low writes strobe again", 32'(commit_reg_o), 1);
    check("R2 consecutive low data", 32'(commit_data_o), 32'h3355);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hi_then_lo();
    t_reuse_latch();
    t_reads();
    t_other_addr();
    t_back_to_back();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule